// File: doc/BRIEF.md
# Pixel De-Blur Filter

This block makes a horizontally smeared RGB video stream sharp again. A first-order low-pass filter upstream mixes each pixel with the one before it. The block reverses that mixing for each colour channel. It takes the incoming pixel and a stored reference pixel and restores an estimate of the original value. The maths is fixed point with S = 4 fractional bits. Each channel gives prev − (prev − cur)·k / 16, clamped to the 8-bit range. The strength coefficient k runs from 16 to 63, and k = 16 leaves the image untouched.

The datapath has three register stages, so it can run at pixel clocks of about 150–160 MHz. The valid strobe, the sync flag, the enable and the unfiltered pixel all pass through the same three stages. When a scaler repeats every source pixel several times, the reference register tracks the line-buffer horizontal offset. This stops a repeated pixel from being compared with a copy of itself.

Top module: `pix_deblur`

## Requirements
- R1: With the enable high and no clamping, each output channel equals (16·prev − (prev − cur)·k) / 16, where prev is the reference pixel and cur is the incoming pixel.
- R2: When 16·prev − (prev − cur)·k is negative, the channel output is 0.
- R3: When 16·prev − (prev − cur)·k is greater than 255·16 = 4080, the channel output is 255.
- R4: While the enable is low, the output is the incoming pixel, unchanged.
- R5: With the enable high and k = 16, the output equals the incoming pixel for any reference value.
- R6: R, G and B are filtered independently. Each channel has its own reference and all three share one coefficient.
- R7: out_valid and out_sync repeat in_valid and in_sync exactly three clocks later. The pixel on the output belongs to the input accepted three clocks earlier.
- R8: With the repeat-mode flag low, each valid input pixel becomes the reference for the next valid pixel. Clocks with in_valid low leave the reference unchanged.
- R9: With the repeat-mode flag high, each valid cycle records the horizontal offset. It also records whether that offset differed from the one recorded on the previous valid cycle. The reference is loaded with the incoming pixel only on a valid cycle that follows such a change. At all other times it holds.
- R10: Reset is synchronous and active high. After reset, out_valid and out_sync are 0 and the output pixels read 0. The reference pixel, the stored offset and the change flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Incoming pixel is valid |
| in_sync | input | 1 | Sync marker, delayed alongside the pixel |
| in_r | input | 8 | Incoming red |
| in_g | input | 8 | Incoming green |
| in_b | input | 8 | Incoming blue |
| en | input | 1 | Filter enable; low passes pixels through |
| coef | input | 6 | Strength k, 16 (off) to 63 |
| rep_mode | input | 1 | Source pixels are repeated by the scaler |
| hofs | input | 11 | Line-buffer horizontal read offset |
| out_valid | output | 1 | Output pixel is valid |
| out_sync | output | 1 | Delayed sync marker |
| out_r | output | 8 | Restored red |
| out_g | output | 8 | Restored green |
| out_b | output | 8 | Restored blue |

## Verification
The bench uses the default build: 8-bit channels, 4 fractional bits, a 6-bit coefficient and an 11-bit offset. With these values k can reach 63. Full-swing edges at that strength push the intermediate value past both ends of the range, so the zero clamp and the 255 clamp are both hit by plain directed pixels. Because the offset is 11 bits, the repeat-mode test can step the offset through a run of source pixels without it wrapping.

// File: rtl/deblur_pkg.sv
package deblur_pkg;

    localparam int PIX_W  = 8;
    localparam int FRAC   = 4;
    localparam int COEF_W = 6;
    localparam int NCH    = 3;

    localparam int DIF_W  = PIX_W + 1;
    localparam int PRD_W  = DIF_W + COEF_W + 1;
    localparam int ACC_W  = PRD_W + 2;

    typedef logic [PIX_W-1:0]         pix_t;
    typedef logic [COEF_W-1:0]        coef_t;
    typedef logic signed [DIF_W-1:0]  dif_t;
    typedef logic signed [PRD_W-1:0]  prd_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef struct packed {
        pix_t r;
        pix_t g;
        pix_t b;
    } rgb_t;

    typedef struct packed {
        logic valid;
        logic sync;
        logic en;
        rgb_t byp;
    } side_t;

    localparam acc_t TOP_LIM = acc_t'(((1 << PIX_W) - 1) << FRAC);

    function automatic pix_t clamp_px(input acc_t v);
        if (v < 0)
            return '0;
        else if (v > TOP_LIM)
            return '1;
        else
            return pix_t'(v >>> FRAC);
    endfunction

endpackage

// File: rtl/deblur_ref_track.sv
module deblur_ref_track
    import deblur_pkg::*;
#(
    parameter int OFS_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vld,
    input  logic             rep,
    input  logic [OFS_W-1:0] hofs,
    input  rgb_t             cur,
    output rgb_t             prev
);

    logic [OFS_W-1:0] hofs_q;
    logic             adv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev   <= '0;
            hofs_q <= '0;
            adv_q  <= 1'b0;
        end else if (vld) begin
            hofs_q <= hofs;
            adv_q  <= (hofs != hofs_q);
            if (!rep || adv_q)
                prev <= cur;
        end
    end

endmodule

// File: rtl/deblur_chan.sv
module deblur_chan
    import deblur_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pix_t  cur,
    input  pix_t  prev,
    input  coef_t coef,
    output pix_t  res
);

    acc_t  base1, base2;
    dif_t  dif1;
    coef_t k1;
    prd_t  prod2;

    always_ff @(posedge clk) begin
        if (rst) begin
            base1 <= '0;
            dif1  <= '0;
            k1    <= '0;
        end else begin
            base1 <= acc_t'({1'b0, prev}) <<< FRAC;
            dif1  <= $signed({1'b0, prev}) - $signed({1'b0, cur});
            k1    <= coef;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base2 <= '0;
            prod2 <= '0;
        end else begin
            base2 <= base1;
            prod2 <= dif1 * $signed({1'b0, k1});
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            res <= '0;
        else
            res <= clamp_px(base2 - acc_t'(prod2));
    end

endmodule

// File: rtl/deblur_side_pipe.sv
module deblur_side_pipe
    import deblur_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  side_t din,
    output side_t dout
);

    side_t stg [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stg
            always_ff @(posedge clk) begin
                if (rst)
                    stg[i] <= '0;
                else if (i == 0)
                    stg[i] <= din;
                else
                    stg[i] <= stg[(i == 0) ? 0 : i - 1];
            end
        end
    endgenerate

    assign dout = stg[DEPTH-1];

endmodule

// File: rtl/pix_deblur.sv
module pix_deblur
    import deblur_pkg::*;
#(
    parameter int OFS_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sync,
    input  logic [7:0]       in_r,
    input  logic [7:0]       in_g,
    input  logic [7:0]       in_b,
    input  logic             en,
    input  logic [5:0]       coef,
    input  logic             rep_mode,
    input  logic [OFS_W-1:0] hofs,
    output logic             out_valid,
    output logic             out_sync,
    output logic [7:0]       out_r,
    output logic [7:0]       out_g,
    output logic [7:0]       out_b
);

    localparam int LAT = 3;

    rgb_t  cur_px, prev_q, filt;
    side_t side_in, side_out;

    assign cur_px = '{r: in_r, g: in_g, b: in_b};

    deblur_ref_track #(.OFS_W(OFS_W)) u_ref (
        .clk  (clk),
        .rst  (rst),
        .vld  (in_valid),
        .rep  (rep_mode),
        .hofs (hofs),
        .cur  (cur_px),
        .prev (prev_q)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            deblur_chan u_ch (
                .clk  (clk),
                .rst  (rst),
                .cur  (cur_px[c*PIX_W +: PIX_W]),
                .prev (prev_q[c*PIX_W +: PIX_W]),
                .coef (coef),
                .res  (filt[c*PIX_W +: PIX_W])
            );
        end
    endgenerate

    assign side_in = '{valid: in_valid, sync: in_sync, en: en, byp: cur_px};

    deblur_side_pipe #(.DEPTH(LAT)) u_side (
        .clk  (clk),
        .rst  (rst),
        .din  (side_in),
        .dout (side_out)
    );

    assign out_valid = side_out.valid;
    assign out_sync  = side_out.sync;
    assign out_r     = side_out.en ? filt.r : side_out.byp.r;
    assign out_g     = side_out.en ? filt.g : side_out.byp.g;
    assign out_b     = side_out.en ? filt.b : side_out.byp.b;

endmodule

// File: rtl/pix_deblur_chk.sv
module pix_deblur_chk
    import deblur_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_sync,
    input logic [7:0] in_r,
    input logic [7:0] in_g,
    input logic [7:0] in_b,
    input logic       en,
    input logic [5:0] coef,
    input logic       rep_mode,
    input logic       out_valid,
    input logic       out_sync,
    input logic [7:0] out_r,
    input logic [7:0] out_g,
    input logic [7:0] out_b,
    input rgb_t       prev_rgb
);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= '0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    assert_valid_lat_R7: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    assert_sync_lat_R7: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (out_sync == $past(in_sync, 3)));

    assert_bypass_R4: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3 && out_valid && !$past(en, 3)) |->
        (out_r == $past(in_r, 3) && out_g == $past(in_g, 3) && out_b == $past(in_b, 3)));

    assert_unity_R5: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3 && out_valid && $past(en, 3) && $past(coef, 3) == 6'd16) |->
        (out_r == $past(in_r, 3) && out_g == $past(in_g, 3) && out_b == $past(in_b, 3)));

    assert_ref_load_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !rep_mode) |=> (prev_rgb == $past({in_r, in_g, in_b})));

    assert_ref_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(prev_rgb));

endmodule

bind pix_deblur pix_deblur_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sync   (in_sync),
    .in_r      (in_r),
    .in_g      (in_g),
    .in_b      (in_b),
    .en        (en),
    .coef      (coef),
    .rep_mode  (rep_mode),
    .out_valid (out_valid),
    .out_sync  (out_sync),
    .out_r     (out_r),
    .out_g     (out_g),
    .out_b     (out_b),
    .prev_rgb  (prev_q)
);

// File: tb/sim_pix_deblur.sv
module sim_pix_deblur;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_sync, en, rep_mode;
    logic [7:0]  in_r, in_g, in_b;
    logic [5:0]  coef;
    logic [10:0] hofs;
    logic        out_valid, out_sync;
    logic [7:0]  out_r, out_g, out_b;

    always #5 clk = ~clk;

    pix_deblur u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sync(in_sync),
        .in_r(in_r), .in_g(in_g), .in_b(in_b), .en(en), .coef(coef),
        .rep_mode(rep_mode), .hofs(hofs), .out_valid(out_valid),
        .out_sync(out_sync), .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // three-deep expectation pipe
    bit    qv [3];
    bit    qs [3];
    int    qr [3];
    int    qg [3];
    int    qb [3];
    string qt [3];

    // reference-pixel model
    int m_pr, m_pg, m_pb, m_hofs;
    bit m_adv;

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int restore(int p, int c, int k, bit e);
        int t;
        if (!e) return c;
        t = p * 16 - (p - c) * k;
        if (t < 0) return 0;
        if (t > 4080) return 255;
        return t / 16;
    endfunction

    task automatic model_reset();
        m_pr = 0; m_pg = 0; m_pb = 0; m_hofs = 0; m_adv = 1'b0;
        for (int i = 0; i < 3; i++) begin
            qv[i] = 1'b0; qs[i] = 1'b0; qr[i] = 0; qg[i] = 0; qb[i] = 0; qt[i] = "R7";
        end
    endtask

    task automatic step(string tag, bit v, bit s, int r, int g, int b, int ofs);
        @(negedge clk);
        chk(qt[2], "out_valid", int'(out_valid), int'(qv[2]));
        if (qv[2]) begin
            chk(qt[2], "out_sync", int'(out_sync), int'(qs[2]));
            chk(qt[2], "out_r", int'(out_r), qr[2]);
            chk(qt[2], "out_g", int'(out_g), qg[2]);
            chk(qt[2], "out_b", int'(out_b), qb[2]);
        end
        for (int i = 2; i > 0; i--) begin
            qv[i] = qv[i-1]; qs[i] = qs[i-1]; qr[i] = qr[i-1];
            qg[i] = qg[i-1]; qb[i] = qb[i-1]; qt[i] = qt[i-1];
        end
        in_valid = v; in_sync = s; hofs = 11'(ofs);
        in_r = 8'(r); in_g = 8'(g); in_b = 8'(b);
        qv[0] = v; qs[0] = s; qt[0] = tag;
        qr[0] = restore(m_pr, r, int'(coef), en);
        qg[0] = restore(m_pg, g, int'(coef), en);
        qb[0] = restore(m_pb, b, int'(coef), en);
        if (v) begin
            if (!rep_mode || m_adv) begin
                m_pr = r; m_pg = g; m_pb = b;
            end
            m_adv = (ofs != m_hofs);
            m_hofs = ofs;
        end
    endtask

    task automatic flush(string tag);
        for (int i = 0; i < 4; i++) step(tag, 1'b0, 1'b0, 0, 0, 0, m_hofs);
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b1; in_sync = 1'b1; en = 1'b1; coef = 6'd40;
        rep_mode = 1'b0; hofs = 11'd5; in_r = 8'd77; in_g = 8'd88; in_b = 8'd99;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R10", "out_valid", int'(out_valid), 0);
        chk("R10", "out_sync", int'(out_sync), 0);
        chk("R10", "out_r", int'(out_r), 0);
        chk("R10", "out_g", int'(out_g), 0);
        chk("R10", "out_b", int'(out_b), 0);
        in_valid = 1'b0; in_sync = 1'b0; hofs = '0;
        rst = 1'b0;
        model_reset();
        // first filtered pixel uses the cleared reference of 0
        en = 1'b1; coef = 6'd32;
        step("R10", 1'b1, 1'b0, 40, 60, 80, 0);
        flush("R10");
    endtask

    task automatic t_bypass();
        en = 1'b0; coef = 6'd63; rep_mode = 1'b0;
        for (int i = 0; i < 8; i++)
            step("R4", 1'b1, 1'b0, (i * 97) % 256, (i * 53 + 11) % 256, 255 - i * 30, 0);
        flush("R4");
    endtask

    task automatic t_unity();
        en = 1'b1; coef = 6'd16;
        for (int i = 0; i < 8; i++)
            step("R5", 1'b1, 1'b0, (i * 71 + 3) % 256, (i & 1) ? 255 : 0, (i * 29) % 256, 0);
        flush("R5");
    endtask

    task automatic t_range();
        en = 1'b1; coef = 6'd24;
        step("R1", 1'b1, 1'b0, 100, 100, 100, 0);
        step("R1", 1'b1, 1'b0, 120, 90, 105, 0);
        step("R1", 1'b1, 1'b0, 110, 95, 100, 0);
        step("R8", 1'b0, 1'b0, 250, 5, 250, 0);
        step("R8", 1'b1, 1'b0, 104, 100, 96, 0);
        step("R8", 1'b1, 1'b0, 98, 102, 100, 0);
        flush("R1");
    endtask

    task automatic t_sat_low();
        en = 1'b1; coef = 6'd63;
        for (int i = 0; i < 6; i++)
            step("R2", 1'b1, 1'b0, (i & 1) ? 0 : 255, (i & 1) ? 10 : 240, (i & 1) ? 0 : 200, 0);
        flush("R2");
    endtask

    task automatic t_sat_high();
        en = 1'b1; coef = 6'd63;
        for (int i = 0; i < 6; i++)
            step("R3", 1'b1, 1'b0, (i & 1) ? 255 : 0, (i & 1) ? 250 : 20, (i & 1) ? 200 : 0, 0);
        flush("R3");
    endtask

    task automatic t_chan();
        en = 1'b1; coef = 6'd48;
        step("R6", 1'b1, 1'b0, 10, 200, 128, 0);
        step("R6", 1'b1, 1'b0, 30, 190, 128, 0);
        step("R6", 1'b1, 1'b0, 25, 210, 0, 0);
        step("R6", 1'b1, 1'b0, 25, 180, 255, 0);
        flush("R6");
    endtask

    task automatic t_gaps();
        en = 1'b1; coef = 6'd36;
        for (int i = 0; i < 12; i++)
            step("R7", (i % 3) != 1, (i % 4) == 0, (i * 41) % 256, (i * 13) % 256, (i * 89) % 256, 0);
        flush("R7");
    endtask

    task automatic t_repeat();
        en = 1'b1; coef = 6'd40; rep_mode = 1'b1;
        for (int j = 1; j <= 6; j++)
            for (int k = 0; k < 3; k++)
                step("R9", 1'b1, 1'b0, (j * 43) % 256, (j * 67 + k) % 256, 255 - j * 35, j);
        step("R9", 1'b0, 1'b0, 0, 0, 0, 7);
        step("R9", 1'b1, 1'b0, 60, 70, 80, 6);
        flush("R9");
        rep_mode = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired before the sequence completed");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_bypass();
        t_unity();
        t_range();
        t_sat_low();
        t_sat_high();
        t_chan();
        t_gaps();
        t_repeat();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule